// File: doc/BRIEF.md
# Saturating Receive Event Counters

This block keeps three 16-bit receive statistics for one 100 Mbps port: false-carrier events, line disconnect events and receive error frames. Event detection upstream delivers single-cycle pulses. The block counts them, and a management register read returns a counter value and clears it. No counter wraps. Each one holds at its all-ones value until software reads it.

The disconnect count has no input of its own. The block derives it from the false-carrier stream. A run is a series of false-carrier pulses with no run-break pulse between them. The disconnect counter advances once, when a run reaches its second pulse. A run-break pulse marks a valid frame or an idle period and ends the current run.

A read is a one-cycle strobe with a 5-bit address. The selected value appears on the read data port after the next clock edge and stays there until the next read.

Top module: `rx_event_stats`

## Requirements
- R1: After reset, every counter reads 0 and rd_data is 0.
- R2: Each cycle with fc_pulse high adds one to the false-carrier counter at address 0x13.
- R3: Each cycle with err_frame_pulse high adds one to the error-frame counter at address 0x15.
- R4: The disconnect counter at address 0x14 adds one in the cycle a false-carrier run reaches two pulses. Further pulses in the same run add nothing.
- R5: A run_break pulse ends the run. When run_break and fc_pulse are both high in one cycle, that pulse starts a new run of length one.
- R6: A counter at 0xFFFF stays at 0xFFFF on further events and does not roll over.
- R7: rd_stb with a counter address loads that counter's value into rd_data at the next clock edge and clears the counter to 0.
- R8: If an event for a counter arrives in the same cycle that counter is read, rd_data returns the old value and the counter becomes 1.
- R9: rd_stb with any other address loads 0 into rd_data and leaves every counter unchanged.
- R10: rd_data keeps its last value in cycles without rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_pulse | input | 1 | One false-carrier event |
| err_frame_pulse | input | 1 | One receive error frame |
| run_break | input | 1 | Valid frame or idle seen; ends a false-carrier run |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Value returned by the last read |

## Verification
Saturation is the hardest case to reach from the ports. It takes 65535 events with no read in between. The bench drives error-frame pulses every cycle for more than 65535 cycles and then checks that the counter holds at all ones. Run tracking is the second hard area, because random pulses seldom line up with run breaks on the same edge. Directed sequences therefore place a break together with a false-carrier pulse, long runs, and a read that coincides with the second pulse of a run.

// File: rtl/rxstat_pkg.sv
// Package: shared widths, register addresses and run-state type for the
// receive event counters. Assumes counters occupy consecutive addresses.
package rxstat_pkg;
    localparam int          CNT_W     = 16;
    localparam int          ADDR_W    = 5;
    localparam int          NUM_CNT   = 3;
    localparam logic [4:0]  ADDR_BASE = 5'h13;   // false carrier at base
    localparam int          IDX_FCAR  = 0;
    localparam int          IDX_DISC  = 1;
    localparam int          IDX_ERRF  = 2;

    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_ONE  = 2'd1,
        RUN_MANY = 2'd2
    } run_state_t;
endpackage

// File: rtl/sat_counter.sv
// Module: sat_counter
// Clear-on-read event counter that saturates at all ones.
// Assumes inc and clr are single-cycle qualified strobes. When both arrive
// together the counter restarts at one so that the event is not lost.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE_VAL = W'(1);

    // Count events, hold at the maximum, clear or restart on read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr && inc)
            cnt <= ONE_VAL;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != MAX_VAL)
            cnt <= cnt + ONE_VAL;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt == MAX_VAL) |=> cnt == MAX_VAL);

    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0);

    // R8
    read_and_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> cnt == ONE_VAL);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != MAX_VAL) |=> cnt == $past(cnt) + ONE_VAL);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fc_run_tracker.sv
// Module: fc_run_tracker
// Follows runs of false-carrier events and flags a disconnect event when a
// run reaches its second event. Assumes a break pulse in the same cycle as
// a false-carrier pulse closes the old run before the new pulse is taken.
module fc_run_tracker
    import rxstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc,
    input  logic brk,
    output logic disc_evt
);
    run_state_t run_q;
    run_state_t run_d;

    // Disconnect event on the second pulse of an unbroken run.
    always_comb begin
        disc_evt = fc && !brk && (run_q == RUN_ONE);
    end

    // Next run length from break and false-carrier inputs.
    always_comb begin
        run_d = run_q;
        if (brk)
            run_d = fc ? RUN_ONE : RUN_NONE;
        else if (fc)
            run_d = (run_q == RUN_NONE) ? RUN_ONE : RUN_MANY;
    end

    // Hold the run length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= RUN_NONE;
        else
            run_q <= run_d;
    end

    // R4
    no_double_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt |=> !disc_evt);

    // R4
    disc_sets_many_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt |=> run_q == RUN_MANY);

    // R5
    break_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && fc) |=> run_q == RUN_ONE);
endmodule

// File: rtl/stat_read_port.sv
// Module: stat_read_port
// Decodes the read address, returns the selected counter and pulses its
// clear. Assumes counters sit at consecutive addresses from ADDR_BASE.
module stat_read_port
    import rxstat_pkg::*;
#(
    parameter int W      = 16,
    parameter int AW     = 5,
    parameter int N      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [AW-1:0]     rd_addr,
    input  logic [N-1:0][W-1:0] cnt_vec,
    output logic [N-1:0]      clr_vec,
    output logic [W-1:0]      rd_data
);
    localparam logic [AW-1:0] BASE = AW'(ADDR_BASE);

    logic [AW-1:0] offset;
    logic          hit;
    logic [W-1:0]  sel_val;

    // Address decode into counter index.
    always_comb begin
        offset = rd_addr - BASE;
        hit    = (rd_addr >= BASE) && (int'(offset) < N);
    end

    // Clear strobe and selected value per counter.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < N; i++) begin
            clr_vec[i] = rd_stb && hit && (int'(offset) == i);
            if (hit && int'(offset) == i)
                sel_val = cnt_vec[i];
        end
    end

    // Capture read data on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= sel_val;
    end

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |=> rd_data == '0);

    // R9
    unmapped_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |-> clr_vec == '0);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R7
    one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: rtl/rx_event_stats.sv
// Module: rx_event_stats (top)
// Three saturating clear-on-read receive counters for one port: false
// carrier, derived disconnect, and error frame. Assumes event inputs are
// single-cycle pulses synchronous to clk.
module rx_event_stats
    import rxstat_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fc_pulse,
    input  logic          err_frame_pulse,
    input  logic          run_break,
    input  logic          rd_stb,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    logic                        disc_evt;
    logic [NUM_CNT-1:0]          inc_vec;
    logic [NUM_CNT-1:0]          clr_vec;
    logic [NUM_CNT-1:0][CW-1:0]  cnt_vec;

    // Map event sources onto counter slots.
    always_comb begin
        inc_vec           = '0;
        inc_vec[IDX_FCAR] = fc_pulse;
        inc_vec[IDX_DISC] = disc_evt;
        inc_vec[IDX_ERRF] = err_frame_pulse;
    end

    fc_run_tracker u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc       (fc_pulse),
        .brk      (run_break),
        .disc_evt (disc_evt)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        sat_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .clr   (clr_vec[g]),
            .cnt   (cnt_vec[g])
        );
    end

    stat_read_port #(.W(CW), .AW(AW), .N(NUM_CNT)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .cnt_vec (cnt_vec),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);
endmodule

// File: tb/rx_event_stats_tb.sv
`timescale 1ns/1ps
module rx_event_stats_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fc_pulse, err_frame_pulse, run_break, rd_stb;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state
    int m_fc, m_dc, m_ef, m_run;

    always #10 clk = ~clk;

    rx_event_stats u_dut (
        .clk(clk), .rst_n(rst_n), .fc_pulse(fc_pulse),
        .err_frame_pulse(err_frame_pulse), .run_break(run_break),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int sat_next(int v, bit inc, bit clr);
        if (clr) return inc ? 1 : 0;
        if (inc && v < 65535) return v + 1;
        return v;
    endfunction

    function automatic int model_read(logic [4:0] a);
        case (a)
            5'h13: return m_fc;
            5'h14: return m_dc;
            5'h15: return m_ef;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, check read at next negedge.
    task automatic cyc(bit fc, bit ef, bit brk, bit rd, logic [4:0] a, string req);
        int  exp_rd;
        bit  dev;
        fc_pulse = fc; err_frame_pulse = ef; run_break = brk;
        rd_stb = rd; rd_addr = a;
        exp_rd = model_read(a);
        dev = fc && !brk && (m_run == 1);
        m_fc = sat_next(m_fc, fc, rd && a == 5'h13);
        m_dc = sat_next(m_dc, dev, rd && a == 5'h14);
        m_ef = sat_next(m_ef, ef, rd && a == 5'h15);
        if (brk) m_run = fc ? 1 : 0;
        else if (fc) m_run = (m_run == 0) ? 1 : 2;
        @(negedge clk);
        fc_pulse = 0; err_frame_pulse = 0; run_break = 0; rd_stb = 0;
        if (rd) check(req, int'(rd_data), exp_rd);
    endtask

    task automatic rd(logic [4:0] a, string req);
        cyc(0, 0, 0, 1, a, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst_n = 0; fc_pulse = 0; err_frame_pulse = 0; run_break = 0;
        rd_stb = 0; rd_addr = '0;
        m_fc = 0; m_dc = 0; m_ef = 0; m_run = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1;
        rd(5'h13, "R1 fcar"); rd(5'h14, "R1 disc"); rd(5'h15, "R1 errf");

        // R2 / R3: simple counts
        repeat (5) cyc(1, 0, 1, 0, 0, "");   // breaks keep runs at one
        repeat (7) cyc(0, 1, 0, 0, 0, "");
        rd(5'h13, "R2 fcar count");
        rd(5'h15, "R3 errf count");
        rd(5'h14, "R5 no disc when broken");

        // R4: run of four gives one disconnect
        repeat (4) cyc(1, 0, 0, 0, 0, "");
        cyc(0, 0, 1, 0, 0, "");
        cyc(1, 0, 0, 0, 0, ""); cyc(0, 0, 0, 0, 0, ""); cyc(1, 0, 0, 0, 0, "");
        rd(5'h14, "R4 disc two runs");
        rd(5'h13, "R2 fcar after runs");

        // R5: break with fc starts new run of one; next fc completes it
        cyc(1, 0, 0, 0, 0, "");
        cyc(1, 0, 1, 0, 0, "");
        rd(5'h14, "R5 break+fc no disc");
        cyc(1, 0, 0, 0, 0, "");
        rd(5'h14, "R5 restarted run");

        // R8: read coincides with event
        cyc(0, 1, 0, 0, 0, ""); cyc(0, 1, 0, 0, 0, "");
        cyc(0, 1, 0, 1, 5'h15, "R8 old value");
        rd(5'h15, "R8 restart at one");
        cyc(0, 0, 1, 0, 0, "");
        cyc(1, 0, 0, 0, 0, "");
        cyc(1, 0, 0, 1, 5'h14, "R8 disc old value");
        rd(5'h14, "R8 disc at one");

        // R9 / R10: unmapped reads, data hold
        repeat (3) cyc(0, 1, 0, 0, 0, "");
        rd(5'h15, "R10 load value");
        repeat (3) cyc(0, 1, 0, 0, 0, "");
        check("R10 hold", int'(rd_data), 3);
        rd(5'h16, "R9 unmapped 16");
        rd(5'h12, "R9 unmapped 12");
        rd(5'h00, "R9 unmapped 00");
        rd(5'h15, "R9 counter untouched");

        // R6: saturation
        for (int i = 0; i < 65540; i++) cyc(0, 1, 0, 0, 0, "");
        rd(5'h15, "R6 saturated");
        rd(5'h15, "R6 cleared after sat");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit fc, ef, brk, r;
            logic [4:0] a;
            fc  = ($urandom % 3) == 0;
            ef  = ($urandom % 4) == 0;
            brk = ($urandom % 5) == 0;
            r   = ($urandom % 6) == 0;
            a   = 5'h12 + 5'($urandom % 5);
            if (($urandom % 20) == 0) a = 5'($urandom);
            cyc(fc, ef, brk, r, a, "R7 random read");
        end
        rd(5'h13, "R2 final"); rd(5'h14, "R4 final"); rd(5'h15, "R3 final");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule